// File: doc/BRIEF.md
# Dual four-bit addressable latch

This block keeps two banks of four storage bits, called bank A and bank B. A single 2-bit address picks one bit position in both banks at the same time. Each bank has its own data input. Two active-low controls, a master clear `mr_n` and an enable `en_n`, choose between four modes:

- **WRITE** (`mr_n`=1, `en_n`=0): each bank's data is stored into the addressed bit.
- **HOLD** (`mr_n`=1, `en_n`=1): nothing changes.
- **DEMUX** (`mr_n`=0, `en_n`=0): a dual 1-of-4 demultiplexer that routes each bank's data to its addressed output.
- **CLEAR** (`mr_n`=0, `en_n`=1): every output is forced low.

Typical uses are serial-to-parallel loading, setting single bits at random, and dual active-high decoding.

Storage is a set of flip-flops on the system clock `clk`. They are written on a rising edge while WRITE is active and zeroed on a rising edge while CLEAR or DEMUX is active. In WRITE and HOLD the outputs show the stored bits. In DEMUX and CLEAR the outputs are combinational from the inputs. The mode decoder is the block's state selector. It moves into any mode from any mode on each cycle, following the two control pins: enter WRITE, enter HOLD, enter DEMUX, enter CLEAR. The bank register is the state that these modes act on.

Top module: `dual_addr_latch`

## Requirements
- R1: In WRITE, on a rising `clk` edge, each bank's addressed bit takes that bank's data input. The other three bits of each bank keep their values. The new value shows on the outputs after the edge.
- R2: In HOLD, all eight outputs stay unchanged across clock edges, whatever the address and data inputs do.
- R3: In DEMUX, each bank's addressed output equals that bank's data input in the same cycle, and the bank's other three outputs are 0.
- R4: In CLEAR, all eight outputs are 0 in the same cycle, whatever the address and data inputs are.
- R5: A rising edge in CLEAR zeroes the stored bits, so a following HOLD or WRITE cycle reads all zeros.
- R6: A rising edge in DEMUX also zeroes the stored bits, so after leaving DEMUX each output reads 0 until it is written again.
- R7: Address value n (0 to 3, with `addr[0]` as the least significant bit) selects output bit n, `qa[n]` and `qb[n]`, in both banks at once.
- R8: In DEMUX with both data inputs at 1, each bank's outputs equal the one-hot code `1 << addr`.
- R9: `q_all` always equals `{qb, qa}`: bank B in bits 7:4 and bank A in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; storage updates on the rising edge |
| mr_n | input | 1 | Master clear, active low |
| en_n | input | 1 | Enable, active low |
| addr | input | 2 | Bit select shared by both banks |
| d_a | input | 1 | Bank A data input |
| d_b | input | 1 | Bank B data input |
| qa | output | 4 | Bank A outputs |
| qb | output | 4 | Bank B outputs |
| q_all | output | 8 | Combined view `{qb, qa}` |

## Verification
The clocked properties assume that `mr_n` is held low from time zero until the first edge, so that the stored bits start from a clear. The bench does this by opening every run with CLEAR cycles. The properties also assume that the address is steady for the whole cycle in which `en_n` is low. The bench follows this rule: in its mixed phase, any cycle whose address differs from the previous cycle's address is forced to `en_n`=1, which corresponds to holding the enable inactive while the address lines move.

// File: rtl/alatch_pkg.sv
package alatch_pkg;

    // Encoded as {mr_n, en_n}
    typedef enum logic [1:0] {
        MODE_DEMUX = 2'b00,
        MODE_CLEAR = 2'b01,
        MODE_WRITE = 2'b10,
        MODE_HOLD  = 2'b11
    } mode_t;

endpackage

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
    import alatch_pkg::*;
(
    input  logic  mr_n,
    input  logic  en_n,
    output mode_t mode
);

    always_comb begin
        unique case ({mr_n, en_n})
            2'b00:   mode = MODE_DEMUX;
            2'b01:   mode = MODE_CLEAR;
            2'b10:   mode = MODE_WRITE;
            default: mode = MODE_HOLD;
        endcase
    end

    always_comb begin
        if (mr_n && en_n) begin
            a_hold_decode_r2: assert (mode == MODE_HOLD);
        end
    end

endmodule

// File: rtl/alatch_bank.sv
module alatch_bank
    import alatch_pkg::*;
#(
    parameter int ADDR_W = 2,
    localparam int NBIT  = 1 << ADDR_W
) (
    input  logic              clk,
    input  mode_t             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic [NBIT-1:0]   q
);

    logic [NBIT-1:0] store;
    logic [NBIT-1:0] store_nxt;
    logic [NBIT-1:0] sel;

    // One-hot bit select decoded from the shared address
    for (genvar i = 0; i < NBIT; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end

    // Next-state process for the stored bits
    always_comb begin
        unique case (mode)
            MODE_WRITE: store_nxt = (store & ~sel) | (sel & {NBIT{din}});
            MODE_HOLD:  store_nxt = store;
            MODE_DEMUX: store_nxt = '0;
            MODE_CLEAR: store_nxt = '0;
            default:    store_nxt = store;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        store <= store_nxt;
    end

    // Output process
    always_comb begin
        unique case (mode)
            MODE_WRITE: q = store;
            MODE_HOLD:  q = store;
            MODE_DEMUX: q = sel & {NBIT{din}};
            MODE_CLEAR: q = '0;
            default:    q = store;
        endcase
    end

    // Assertions
    p_write_lands_r1: assert property (@(posedge clk)
        disable iff (mode == MODE_CLEAR || mode == MODE_DEMUX)
        (mode == MODE_WRITE) |=> (q[$past(addr)] == $past(din)));

    p_single_change_r1: assert property (@(posedge clk)
        disable iff (mode == MODE_CLEAR || mode == MODE_DEMUX)
        (mode == MODE_WRITE) |=> ($countones(q ^ $past(q)) <= 1));

    p_hold_stable_r2: assert property (@(posedge clk)
        disable iff (mode == MODE_CLEAR || mode == MODE_DEMUX)
        (mode == MODE_HOLD) |=> $stable(q));

    p_after_clear_r5: assert property (@(posedge clk)
        disable iff (mode == MODE_DEMUX)
        (mode == MODE_CLEAR) |=> (q == '0));

    p_after_demux_r6: assert property (@(posedge clk)
        disable iff (mode == MODE_DEMUX)
        ($past(mode) == MODE_DEMUX) |-> (q == '0));

    always_comb begin
        if (mode == MODE_DEMUX) begin
            a_demux_onehot_r3: assert ($countones(q) <= 1);
            a_demux_follow_r3: assert (q[addr] == din);
        end
        if (mode == MODE_CLEAR) begin
            a_clear_low_r4: assert (q == '0);
        end
    end

endmodule

// File: rtl/dual_addr_latch.sv
module dual_addr_latch
    import alatch_pkg::*;
#(
    parameter int ADDR_W = 2,
    localparam int NBIT  = 1 << ADDR_W,
    localparam int NBANK = 2
) (
    input  logic              clk,
    input  logic              mr_n,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              d_a,
    input  logic              d_b,
    output logic [NBIT-1:0]   qa,
    output logic [NBIT-1:0]   qb,
    output logic [NBANK*NBIT-1:0] q_all
);

    mode_t           mode;
    logic [NBANK-1:0] din;
    logic [NBIT-1:0]  bank_q [NBANK];

    alatch_mode_dec u_mode (
        .mr_n (mr_n),
        .en_n (en_n),
        .mode (mode)
    );

    assign din = {d_b, d_a};

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        alatch_bank #(.ADDR_W(ADDR_W)) u_bank (
            .clk  (clk),
            .mode (mode),
            .addr (addr),
            .din  (din[b]),
            .q    (bank_q[b])
        );
    end

    assign qa    = bank_q[0];
    assign qb    = bank_q[1];
    assign q_all = {bank_q[1], bank_q[0]};

    // Both banks answer the same address in DEMUX (R7)
    p_same_position_r7: assert property (@(posedge clk)
        disable iff (mr_n)
        (!en_n && d_a && d_b) |-> (qa == qb));

endmodule

// File: tb/test_dual_addr_latch.sv
`timescale 1ns/1ps
module test_dual_addr_latch;

    logic       clk  = 1'b0;
    logic       mr_n = 1'b0;
    logic       en_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic       d_a  = 1'b0;
    logic       d_b  = 1'b0;
    logic [3:0] qa;
    logic [3:0] qb;
    logic [7:0] q_all;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference state: mem[bank][bit]
    bit mem [2][4];
    int prev_mode = 1;   // 0 demux, 1 clear, 2 write, 3 hold
    string force_tag = "";

    always #2 clk = ~clk;   // 250 MHz

    dual_addr_latch i_dual_addr_latch (
        .clk   (clk),
        .mr_n  (mr_n),
        .en_n  (en_n),
        .addr  (addr),
        .d_a   (d_a),
        .d_b   (d_b),
        .qa    (qa),
        .qb    (qb),
        .q_all (q_all)
    );

    function automatic logic [3:0] expect_bank(int b, bit din);
        logic [3:0] r;
        int m;
        r = '0;
        m = {mr_n, en_n};
        if (m == 2 || m == 3) begin
            for (int i = 0; i < 4; i++) r[i] = mem[b][i];
        end else if (m == 0) begin
            r[addr] = din;
        end
        return r;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(bit mr, bit en, logic [1:0] ad, bit da, bit db);
        logic [3:0] ea;
        logic [3:0] eb;
        string tag;
        int m;
        @(negedge clk);
        mr_n = mr; en_n = en; addr = ad; d_a = da; d_b = db;
        #1;
        m = {mr, en};
        if (m == 2)                       tag = "R1";
        else if (m == 3 && prev_mode == 1) tag = "R5";
        else if (m == 3 && prev_mode == 0) tag = "R6";
        else if (m == 3)                  tag = "R2";
        else if (m == 0 && da && db)      tag = "R8";
        else if (m == 0)                  tag = "R3";
        else                              tag = "R4";
        if (force_tag != "") tag = force_tag;
        ea = expect_bank(0, da);
        eb = expect_bank(1, db);
        check({tag, " qa"}, {4'b0, qa}, {4'b0, ea});
        check({tag, " qb"}, {4'b0, qb}, {4'b0, eb});
        check("R9 q_all", q_all, {eb, ea});
        @(posedge clk);
        if (m == 2) begin
            mem[0][ad] = da;
            mem[1][ad] = db;
        end else if (m == 0 || m == 1) begin
            for (int b = 0; b < 2; b++)
                for (int i = 0; i < 4; i++) mem[b][i] = 1'b0;
        end
        prev_mode = m;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] last_ad;
        void'($urandom(13));
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 4; i++) mem[b][i] = 1'b0;

        // Reset state through CLEAR (R4), then HOLD after clear (R5)
        step(0, 1, 2'd2, 1, 1);
        step(0, 1, 2'd1, 0, 1);
        step(1, 1, 2'd3, 1, 1);

        // R7: walk addresses, distinct data per bank
        force_tag = "R7";
        step(1, 0, 2'd0, 1, 0);
        step(1, 0, 2'd3, 0, 1);
        step(1, 0, 2'd1, 1, 1);
        step(1, 1, 2'd1, 0, 0);
        step(1, 0, 2'd2, 0, 1);
        force_tag = "";

        // R2: hold under changing inputs
        for (int k = 0; k < 8; k++) step(1, 1, 2'(k), k[0], k[1]);

        // R1: overwrite one bit, others kept
        step(1, 0, 2'd0, 0, 1);
        step(1, 1, 2'd0, 0, 1);

        // R8 decoder, then R3 with zero / mixed data
        for (int k = 0; k < 4; k++) step(0, 0, 2'(k), 1, 1);
        for (int k = 0; k < 4; k++) step(0, 0, 2'(k), k[0], 0);
        // R6: storage reads low after demux
        step(1, 1, 2'd3, 1, 1);
        step(1, 1, 2'd2, 0, 0);

        // Write, then R4 clear with busy inputs, then R5
        step(1, 0, 2'd1, 1, 1);
        step(1, 0, 2'd2, 1, 1);
        step(1, 1, 2'd2, 1, 1);
        step(0, 1, 2'd3, 1, 1);
        step(1, 1, 2'd0, 1, 0);
        step(1, 0, 2'd0, 1, 0);

        // Mixed phase: enable held inactive whenever the address moves
        last_ad = 2'd0;
        for (int k = 0; k < 800; k++) begin
            logic [1:0] ad;
            bit mr, en;
            ad = 2'($urandom_range(0, 3));
            mr = ($urandom_range(0, 7) != 0);
            en = $urandom_range(0, 1) == 1;
            if (ad != last_ad) en = 1'b1;
            step(mr, en, ad, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            last_ad = ad;
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule